// File: doc/BRIEF.md
# Floating-Point Coprocessor Instruction Decoder and Register Mover

This block sits beside a core's issue stage and takes 32-bit floating-point coprocessor instruction words, one per cycle, under a valid strobe. It recognises the coprocessor's instruction space by two fixed nibbles. It builds 5-bit register numbers from a 4-bit field plus a separate high bit, and it sorts each word into one of five classes: two-source arithmetic, one-source arithmetic, format conversion, compare, and register move. The decoded operation, the operand indices, the compare condition and an illegal-instruction flag are registered and presented one cycle after the word is accepted.

Arithmetic itself is done elsewhere. Register moves are carried out by the block. It holds a 32-entry floating register file and a 16-entry control register file. It reads a core general register through a combinational index/data pair, and it returns values to the core through a registered write-back port. Control entry 0 is a read-only identification value. Entry 1 holds compare results and entry 15 holds error state. All other entries are plain storage.

Top module: `fpc_insn_unit`

## Requirements
- R1: A word belongs to the coprocessor only if bits [31:28] = 0xF and bits [19:16] = 0x7. Any other word gives out_cls = 0 and out_op = 0, keeps out_illegal low, and writes no register.
- R2: For every accepted word, out_rd = {bit 3, bits [27:24]}, out_rs1 = {bit 2, bits [11:8]} and out_rs2 = {bit 1, bits [7:4]}.
- R3: With sub-op bits [15:12] = 0, function bits [23:20] = 0..3 give class 1 with op 1..4 (add, subtract, multiply, divide). Function bits 4..7 give class 2 with op 5..8 (square root, absolute value, move, negate).
- R4: All of the following are class 3. Sub-op 0 with function 0xC..0xF gives op 9..12 (round, truncate, ceiling and floor to integer). Sub-op 1 with function 4 gives op 13 (float to integer). Sub-op 9 with function 0 gives op 14 (integer to float).
- R5: Sub-op 2 is a compare: class 4, op 15, and out_cond = bits [23:20]. Bits [27:24] and bit 3 must be zero. out_cond is 0 whenever out_cls is not 4.
- R6: Every arithmetic, conversion and compare word requires bit 0 = 0. One-source and conversion words also require bits [7:4] = 0 and bit 1 = 0. A prefixed word that breaks a must-be-zero rule, or that uses an unlisted sub-op/function pair, sets out_illegal and reports class 0 and op 0. Such a word writes no register and issues no write-back.
- R7: Sub-op 0xF is a move (class 5). It requires bits [11:4] = 0 and bit 2 = 0. Bit 1 = 0 selects the floating file and bit 1 = 1 selects the control file. Bit 0 = 0 selects core-to-coprocessor. This gives op 16 (core to floating) or op 18 (core to control). The core register index is bits [23:20], presented at once on core_rd_idx.
- R8: A move with bit 0 = 1 is coprocessor-to-core: op 17 (floating) or op 19 (control). One cycle later it raises core_wb_en, with core_wb_idx = bits [23:20] and core_wb_data = the register value.
- R9: A control move indexes the control file with bits [27:24] and requires bit 3 = 0. Indices 1 to 15 store and return the written value.
- R10: Control index 0 always reads ID_VALUE. Writes to it change nothing.
- R11: After reset, all outputs are 0 and every floating and writable control register reads 0.
- R12: A move completes in one cycle. A read issued in the cycle after a write to the same floating register returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_vld | input | 1 | Instruction word valid this cycle |
| insn | input | 32 | Instruction word |
| core_rd_data | input | DW | Core register value at core_rd_idx |
| core_rd_idx | output | 4 | Core register index for a core-to-coprocessor move |
| out_vld | output | 1 | Decoded outputs belong to a word accepted last cycle |
| out_cls | output | 3 | Class: 0 none, 1 two-source, 2 one-source, 3 conversion, 4 compare, 5 move |
| out_op | output | 5 | Operation code, 0 for none |
| out_cond | output | 4 | Compare condition |
| out_rd | output | 5 | Destination index |
| out_rs1 | output | 5 | First source index |
| out_rs2 | output | 5 | Second source index |
| out_illegal | output | 1 | Prefixed word with a bad encoding |
| core_wb_en | output | 1 | Core register write-back strobe |
| core_wb_idx | output | 4 | Core register to write |
| core_wb_data | output | DW | Value to write |

## Verification
The bench sweeps all 256 sub-op/function pairs. For each pair it tries every value of the low nibble and both clean and dirty values in the other must-be-zero fields. This exposes a decoder that forgets a zero rule, which would classify a bad word as legal, or one that applies the wrong rule to a class, which would flag good unary or compare words. Every floating and control register is written and read back. Doing so catches a misplaced high index bit, which would alias entries 0 and 16. It also catches a writable identification entry, which would return the written value instead of the fixed one. Illegal moves and words with a wrong prefix are each followed by a read-back to show that nothing was written. A write followed at once by a read of the same register shows that the new value is returned on the next cycle.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam logic [3:0] PFX_HI  = 4'hF;
  localparam logic [3:0] PFX_MID = 4'h7;
  localparam int         FR_DEPTH = 32;
  localparam int         CR_DEPTH = 16;
  localparam int         FR_AW = $clog2(FR_DEPTH);
  localparam int         CR_AW = $clog2(CR_DEPTH);

  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_BIN  = 3'd1,
    CLS_UNA  = 3'd2,
    CLS_CONV = 3'd3,
    CLS_CMP  = 3'd4,
    CLS_MOVE = 3'd5
  } fpc_cls_e;

  typedef enum logic [4:0] {
    OP_NONE  = 5'd0,
    OP_ADD   = 5'd1,
    OP_SUB   = 5'd2,
    OP_MUL   = 5'd3,
    OP_DIV   = 5'd4,
    OP_SQRT  = 5'd5,
    OP_ABS   = 5'd6,
    OP_FMOV  = 5'd7,
    OP_NEG   = 5'd8,
    OP_RNDW  = 5'd9,
    OP_TRNW  = 5'd10,
    OP_CEILW = 5'd11,
    OP_FLRW  = 5'd12,
    OP_F2W   = 5'd13,
    OP_W2F   = 5'd14,
    OP_CMP   = 5'd15,
    OP_C2F   = 5'd16,
    OP_F2C   = 5'd17,
    OP_C2X   = 5'd18,
    OP_X2C   = 5'd19
  } fpc_op_e;

  typedef struct packed {
    fpc_cls_e   cls;
    fpc_op_e    op;
    logic       illegal;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic [3:0] cond;
    logic [3:0] core_idx;
  } fpc_dec_t;

endpackage

// File: rtl/fpc_rst_sync.sv
module fpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/fpc_decode.sv
module fpc_decode
  import fpc_pkg::*;
(
  input  logic [31:0] word,
  output fpc_dec_t    dec
);

  logic     pfx, legal, ok;
  logic     z_arith, z_one_src, z_cmp, z_move;
  logic [3:0] fop, sub;
  fpc_cls_e cls;
  fpc_op_e  op;

  always_comb begin
    pfx = (word[31:28] == PFX_HI) && (word[19:16] == PFX_MID);
    fop = word[23:20];
    sub = word[15:12];

    // must-be-zero groups
    z_arith   = !word[0];
    z_one_src = !word[1] && (word[7:4] == 4'h0);
    z_cmp     = !word[3] && (word[27:24] == 4'h0);
    z_move    = (word[11:4] == 8'h00) && !word[2] && !(word[1] && word[3]);

    cls = CLS_NONE;
    op  = OP_NONE;
    case (sub)
      4'h0: begin
        case (fop)
          4'h0: begin cls = CLS_BIN;  op = OP_ADD;   end
          4'h1: begin cls = CLS_BIN;  op = OP_SUB;   end
          4'h2: begin cls = CLS_BIN;  op = OP_MUL;   end
          4'h3: begin cls = CLS_BIN;  op = OP_DIV;   end
          4'h4: begin cls = CLS_UNA;  op = OP_SQRT;  end
          4'h5: begin cls = CLS_UNA;  op = OP_ABS;   end
          4'h6: begin cls = CLS_UNA;  op = OP_FMOV;  end
          4'h7: begin cls = CLS_UNA;  op = OP_NEG;   end
          4'hC: begin cls = CLS_CONV; op = OP_RNDW;  end
          4'hD: begin cls = CLS_CONV; op = OP_TRNW;  end
          4'hE: begin cls = CLS_CONV; op = OP_CEILW; end
          4'hF: begin cls = CLS_CONV; op = OP_FLRW;  end
          default: begin cls = CLS_NONE; op = OP_NONE; end
        endcase
      end
      4'h1: begin
        if (fop == 4'h4) begin cls = CLS_CONV; op = OP_F2W; end
      end
      4'h9: begin
        if (fop == 4'h0) begin cls = CLS_CONV; op = OP_W2F; end
      end
      4'h2: begin cls = CLS_CMP; op = OP_CMP; end
      4'hF: begin
        cls = CLS_MOVE;
        case ({word[1], word[0]})
          2'b00:   op = OP_C2F;
          2'b01:   op = OP_F2C;
          2'b10:   op = OP_C2X;
          default: op = OP_X2C;
        endcase
      end
      default: begin cls = CLS_NONE; op = OP_NONE; end
    endcase

    case (cls)
      CLS_BIN:           ok = z_arith;
      CLS_UNA, CLS_CONV: ok = z_arith && z_one_src;
      CLS_CMP:           ok = z_arith && z_cmp;
      CLS_MOVE:          ok = z_move;
      default:           ok = 1'b0;
    endcase

    legal        = pfx && ok;
    dec.cls      = legal ? cls : CLS_NONE;
    dec.op       = legal ? op  : OP_NONE;
    dec.illegal  = pfx && !legal;
    dec.cond     = (legal && (cls == CLS_CMP)) ? fop : 4'h0;
    dec.rd       = {word[3], word[27:24]};
    dec.rs1      = {word[2], word[11:8]};
    dec.rs2      = {word[1], word[7:4]};
    dec.core_idx = fop;
  end

endmodule

// File: rtl/fpc_regfile.sv
module fpc_regfile #(
  parameter int               DEPTH   = 32,
  parameter int               WIDTH   = 32,
  parameter bit               HAS_RO0 = 1'b0,
  parameter logic [WIDTH-1:0] RO_VAL  = '0,
  localparam int              AW      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (HAS_RO0 && (i == 0)) begin : g_ro
      assign ent[i] = RO_VAL;
    end else begin : g_rw
      logic             wen;
      logic [WIDTH-1:0] val_q;
      assign wen = we && (waddr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= '0;
        end else if (wen) begin
          val_q <= wdata;
        end
      end
      assign ent[i] = val_q;
    end
  end

  assign rdata = ent[raddr];

endmodule

// File: rtl/fpc_insn_unit.sv
module fpc_insn_unit
  import fpc_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [DW-1:0] ID_VALUE = 32'hC0DE_0104
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_vld,
  input  logic [31:0]   insn,
  input  logic [DW-1:0] core_rd_data,
  output logic [3:0]    core_rd_idx,
  output logic          out_vld,
  output logic [2:0]    out_cls,
  output logic [4:0]    out_op,
  output logic [3:0]    out_cond,
  output logic [4:0]    out_rd,
  output logic [4:0]    out_rs1,
  output logic [4:0]    out_rs2,
  output logic          out_illegal,
  output logic          core_wb_en,
  output logic [3:0]    core_wb_idx,
  output logic [DW-1:0] core_wb_data
);

  logic     rst_q_n;
  fpc_dec_t dec;
  logic     fr_we, cr_we;
  logic [DW-1:0] fr_rdata, cr_rdata;

  // next-state
  logic          vld_d, ill_d, wb_en_d, idx_en;
  fpc_cls_e      cls_d;
  fpc_op_e       op_d;
  logic [3:0]    cond_d;
  logic [DW-1:0] wb_data_d;

  // state
  logic          vld_q, ill_q, wb_en_q;
  fpc_cls_e      cls_q;
  fpc_op_e       op_q;
  logic [3:0]    cond_q, wb_idx_q;
  logic [4:0]    rd_q, rs1_q, rs2_q;
  logic [DW-1:0] wb_data_q;

  fpc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  fpc_decode u_dec (
    .word (insn),
    .dec  (dec)
  );

  assign core_rd_idx = dec.core_idx;
  assign fr_we = insn_vld && (dec.op == OP_C2F);
  assign cr_we = insn_vld && (dec.op == OP_C2X);

  fpc_regfile #(
    .DEPTH (FR_DEPTH), .WIDTH (DW), .HAS_RO0 (1'b0), .RO_VAL ('0)
  ) u_fr (
    .clk   (clk),
    .rst_n (rst_q_n),
    .we    (fr_we),
    .waddr (dec.rd),
    .wdata (core_rd_data),
    .raddr (dec.rd),
    .rdata (fr_rdata)
  );

  fpc_regfile #(
    .DEPTH (CR_DEPTH), .WIDTH (DW), .HAS_RO0 (1'b1), .RO_VAL (ID_VALUE)
  ) u_cr (
    .clk   (clk),
    .rst_n (rst_q_n),
    .we    (cr_we),
    .waddr (dec.rd[CR_AW-1:0]),
    .wdata (core_rd_data),
    .raddr (dec.rd[CR_AW-1:0]),
    .rdata (cr_rdata)
  );

  always_comb begin
    vld_d     = insn_vld;
    idx_en    = insn_vld;
    cls_d     = insn_vld ? dec.cls : CLS_NONE;
    op_d      = insn_vld ? dec.op  : OP_NONE;
    ill_d     = insn_vld && dec.illegal;
    cond_d    = insn_vld ? dec.cond : 4'h0;
    wb_en_d   = insn_vld && ((dec.op == OP_F2C) || (dec.op == OP_X2C));
    wb_data_d = (dec.op == OP_X2C) ? cr_rdata : fr_rdata;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q     <= 1'b0;
      cls_q     <= CLS_NONE;
      op_q      <= OP_NONE;
      ill_q     <= 1'b0;
      cond_q    <= 4'h0;
      wb_en_q   <= 1'b0;
      rd_q      <= '0;
      rs1_q     <= '0;
      rs2_q     <= '0;
      wb_idx_q  <= '0;
      wb_data_q <= '0;
    end else begin
      vld_q   <= vld_d;
      cls_q   <= cls_d;
      op_q    <= op_d;
      ill_q   <= ill_d;
      cond_q  <= cond_d;
      wb_en_q <= wb_en_d;
      if (idx_en) begin
        rd_q  <= dec.rd;
        rs1_q <= dec.rs1;
        rs2_q <= dec.rs2;
      end
      if (wb_en_d) begin
        wb_idx_q  <= dec.core_idx;
        wb_data_q <= wb_data_d;
      end
    end
  end

  assign out_vld      = vld_q;
  assign out_cls      = cls_q;
  assign out_op       = op_q;
  assign out_cond     = cond_q;
  assign out_rd       = rd_q;
  assign out_rs1      = rs1_q;
  assign out_rs2      = rs2_q;
  assign out_illegal  = ill_q;
  assign core_wb_en   = wb_en_q;
  assign core_wb_idx  = wb_idx_q;
  assign core_wb_data = wb_data_q;

endmodule

// File: rtl/fpc_insn_unit_chk.sv
module fpc_insn_unit_chk
  import fpc_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] ID_VALUE = 32'hC0DE_0104
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_vld,
  input logic          out_vld,
  input logic [2:0]    out_cls,
  input logic [4:0]    out_op,
  input logic [3:0]    out_cond,
  input logic [4:0]    out_rd,
  input logic          out_illegal,
  input logic          core_wb_en,
  input logic [DW-1:0] core_wb_data
);

  // R6: a rejected word carries no operation and no write-back
  a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (!core_wb_en && out_cls == 3'd0 && out_op == 5'd0));

  // R1: with no accepted word, nothing is reported
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (!out_illegal && out_cls == 3'd0 && !core_wb_en));

  // R8: write-back only follows a coprocessor-to-core move
  a_r8_wb_from_move: assert property (@(posedge clk) disable iff (!rst_n)
    core_wb_en |-> (out_cls == 3'(CLS_MOVE) &&
                    (out_op == 5'(OP_F2C) || out_op == 5'(OP_X2C))));

  // R5: condition is only non-zero on a compare
  a_r5_cond_cmp_only: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cls != 3'(CLS_CMP)) |-> (out_cond == 4'h0));

  // R10: identification entry always reads its fixed value
  a_r10_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wb_en && out_op == 5'(OP_X2C) && out_rd == 5'd0) |->
      (core_wb_data == ID_VALUE));

  // R12: outputs appear exactly one cycle after acceptance
  a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(insn_vld));

  // R3: two-source class carries only ops 1..4
  a_r3_bin_ops: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cls == 3'(CLS_BIN)) |-> (out_op >= 5'd1 && out_op <= 5'd4));

endmodule

bind fpc_insn_unit fpc_insn_unit_chk #(.DW(DW), .ID_VALUE(ID_VALUE)) u_chk (.*);

// File: tb/test_fpc_insn_unit.sv
`timescale 1ns/1ps
module test_fpc_insn_unit;

  localparam logic [31:0] ID = 32'h5A17_0C39;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_vld;
  logic [31:0] insn;
  logic [31:0] core_rd_data;
  logic [3:0]  core_rd_idx;
  logic        out_vld;
  logic [2:0]  out_cls;
  logic [4:0]  out_op;
  logic [3:0]  out_cond;
  logic [4:0]  out_rd, out_rs1, out_rs2;
  logic        out_illegal;
  logic        core_wb_en;
  logic [3:0]  core_wb_idx;
  logic [31:0] core_wb_data;

  logic [31:0] core_regs [16];
  logic [31:0] fr_model  [32];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign core_rd_data = core_regs[core_rd_idx];

  fpc_insn_unit #(.DW(32), .ID_VALUE(ID)) i_fpc_insn_unit (
    .clk, .rst_n, .insn_vld, .insn, .core_rd_data, .core_rd_idx,
    .out_vld, .out_cls, .out_op, .out_cond, .out_rd, .out_rs1, .out_rs2,
    .out_illegal, .core_wb_en, .core_wb_idx, .core_wb_data
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // accept one word on the next rising edge; returns at the following falling edge
  task automatic issue(input logic [31:0] w);
    insn = w;
    insn_vld = 1'b1;
    @(negedge clk);
    insn_vld = 1'b0;
  endtask

  function automatic logic [31:0] mv(input bit to_core, input bit ctl,
                                     input logic [4:0] idx, input logic [3:0] creg);
    return {4'hF, idx[3:0], creg, 4'h7, 4'hF, 8'h00, idx[4], 1'b0, ctl, to_core};
  endfunction

  // expected {illegal, cls, op} from the requirement text
  function automatic logic [8:0] model(input logic [31:0] w);
    logic [3:0] fo, sb;
    logic [2:0] c;
    logic [4:0] o;
    bit ok;
    fo = w[23:20];
    sb = w[15:12];
    if (!(w[31:28] == 4'hF && w[19:16] == 4'h7)) return 9'd0;
    c = 3'd0; o = 5'd0; ok = 1'b0;
    if (sb == 4'h0 && fo < 4) begin
      c = 3'd1; o = 5'(fo) + 5'd1; ok = !w[0];
    end else if (sb == 4'h0 && fo < 8) begin
      c = 3'd2; o = 5'(fo) + 5'd1; ok = !w[0] && !w[1] && w[7:4] == 0;
    end else if (sb == 4'h0 && fo >= 12) begin
      c = 3'd3; o = 5'(fo) - 5'd3; ok = !w[0] && !w[1] && w[7:4] == 0;
    end else if ((sb == 4'h1 && fo == 4'h4) || (sb == 4'h9 && fo == 4'h0)) begin
      c = 3'd3; o = (sb == 4'h1) ? 5'd13 : 5'd14; ok = !w[0] && !w[1] && w[7:4] == 0;
    end else if (sb == 4'h2) begin
      c = 3'd4; o = 5'd15; ok = !w[0] && !w[3] && w[27:24] == 0;
    end else if (sb == 4'hF) begin
      c = 3'd5; o = 5'd16 + 5'({w[1], w[0]});
      ok = w[11:4] == 0 && !w[2] && !(w[1] && w[3]);
    end
    if (!ok) return {1'b1, 8'd0};
    return {1'b0, c, o};
  endfunction

  initial begin
    #1_900_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [8:0]  e;
    logic [31:0] w;
    string tag;
    for (int i = 0; i < 16; i++) core_regs[i] = 32'h0;
    rst_n = 1'b0;
    insn_vld = 1'b0;
    insn = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    chk("R11", "vld/cls/op/ill/wb", {out_vld, out_cls, out_op, out_illegal, core_wb_en}, 0);
    issue(mv(1, 0, 5'd31, 4'd2));
    chk("R11", "fr31 after reset", {core_wb_en, core_wb_data}, {1'b1, 32'h0});
    issue(mv(1, 1, 5'd15, 4'd3));
    chk("R11", "cr15 after reset", {core_wb_en, core_wb_data}, {1'b1, 32'h0});

    // decode sweep: every sub-op/function pair against must-be-zero patterns
    for (int fo = 0; fo < 16; fo++) begin
      for (int sb = 0; sb < 16; sb++) begin
        for (int lo = 0; lo < 16; lo++) begin
          for (int m = 0; m < 8; m++) begin
            w = {4'hF, (m[2] ? 4'h3 : 4'h0), 4'(fo), 4'h7, 4'(sb),
                 (m[1] ? 4'hA : 4'h0), (m[0] ? 4'h5 : 4'h0), 4'(lo)};
            e = model(w);
            issue(w);
            if (e[8])               tag = "R6";
            else if (e[7:5] == 3'd1 || e[7:5] == 3'd2) tag = "R3";
            else if (e[7:5] == 3'd3) tag = "R4";
            else if (e[7:5] == 3'd4) tag = "R5";
            else                    tag = "R7";
            chk(tag, $sformatf("decode %h", w),
                {out_illegal, out_cls, out_op, out_cond, core_wb_en},
                {e, (e[7:5] == 3'd4) ? 4'(fo) : 4'h0,
                 (e[4:0] == 5'd17 || e[4:0] == 5'd19)});
            chk("R2", $sformatf("indices %h", w), {out_rd, out_rs1, out_rs2},
                {w[3], w[27:24], w[2], w[11:8], w[1], w[7:4]});
          end
        end
      end
    end

    // R7 / R8: fill every floating register, then read all back
    for (int k = 0; k < 32; k++) begin
      fr_model[k] = 32'hA500_0000 ^ (32'(k) * 32'h0001_0203);
      core_regs[k % 16] = fr_model[k];
      issue(mv(0, 0, 5'(k), 4'(k % 16)));
      chk("R7", "core-to-float op", {out_cls, out_op, core_wb_en}, {3'd5, 5'd16, 1'b0});
    end
    for (int k = 0; k < 32; k++) begin
      issue(mv(1, 0, 5'(k), 4'(15 - (k % 16))));
      chk("R8", $sformatf("float %0d to core", k),
          {core_wb_en, core_wb_idx, core_wb_data},
          {1'b1, 4'(15 - (k % 16)), fr_model[k]});
    end

    // R12: write then immediately read the same register
    core_regs[3] = 32'hDEAD_BEEF;
    issue(mv(0, 0, 5'd9, 4'd3));
    issue(mv(1, 0, 5'd9, 4'd4));
    chk("R12", "back-to-back read", {core_wb_en, core_wb_data}, {1'b1, 32'hDEAD_BEEF});
    fr_model[9] = 32'hDEAD_BEEF;

    // R9: control registers
    for (int c = 1; c < 16; c++) begin
      core_regs[c] = 32'h7700_0000 + 32'(c * 17);
      issue(mv(0, 1, 5'(c), 4'(c)));
      chk("R9", "core-to-control op", {out_cls, out_op}, {3'd5, 5'd18});
    end
    for (int c = 1; c < 16; c++) begin
      issue(mv(1, 1, 5'(c), 4'd0));
      chk("R9", $sformatf("control %0d readback", c), {core_wb_en, core_wb_data},
          {1'b1, 32'h7700_0000 + 32'(c * 17)});
    end
    core_regs[6] = 32'h1234_5678;
    issue(mv(0, 1, 5'd21, 4'd6));
    chk("R9", "control move with bit 3 set", {out_illegal, out_cls}, {1'b1, 3'd0});
    issue(mv(1, 1, 5'd5, 4'd0));
    chk("R9", "control 5 unchanged", core_wb_data, 32'h7700_0000 + 32'd85);

    // R10: identification entry
    core_regs[1] = 32'hFFFF_FFFF;
    issue(mv(0, 1, 5'd0, 4'd1));
    issue(mv(1, 1, 5'd0, 4'd7));
    chk("R10", "id after write", {core_wb_en, core_wb_idx, core_wb_data}, {1'b1, 4'd7, ID});

    // R6: illegal moves must not write
    core_regs[2] = 32'h0BAD_0BAD;
    issue(mv(0, 0, 5'd3, 4'd2) | 32'h0000_0004);
    chk("R6", "bit2 move flagged", {out_illegal, core_wb_en}, 2'b10);
    issue(mv(0, 0, 5'd3, 4'd2) | 32'h0000_0100);
    chk("R6", "bits11:4 move flagged", out_illegal, 1'b1);
    issue(mv(1, 0, 5'd3, 4'd0));
    chk("R6", "fr3 unchanged", core_wb_data, fr_model[3]);

    // R1: wrong prefix is ignored
    issue(mv(0, 0, 5'd4, 4'd2) & 32'hFFF6_FFFF);
    chk("R1", "mid nibble 6", {out_vld, out_illegal, out_cls, out_op}, {1'b1, 1'b0, 8'd0});
    issue(mv(0, 0, 5'd4, 4'd2) & 32'hEFFF_FFFF);
    chk("R1", "top nibble E", {out_vld, out_illegal, out_cls, out_op}, {1'b1, 1'b0, 8'd0});
    issue(mv(1, 0, 5'd4, 4'd0));
    chk("R1", "fr4 unchanged", core_wb_data, fr_model[4]);
    @(negedge clk);
    chk("R1", "idle after stream", {out_vld, core_wb_en}, 2'b00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule